// File: doc/BRIEF.md
# SPI Command/Response Transaction Master

This block is a byte-wide SPI master that carries out one whole command-then-response exchange while chip select stays low. Before it starts an exchange, a host gives it two counts: how many command bytes to send and how many response bytes to collect. The host feeds the command bytes into a small transmit store and reads the response bytes out of a small receive store. The engine first shifts out the command bytes. It then clocks out zero filler bytes so the response can be shifted in. Bytes that arrive while commands are being sent are dropped inside the block. Only bytes from the response slots reach the receive store.

The link uses clock mode 0 and sends the most significant bit first. The serial clock is the input clock divided by `PRESCALE*(1+RATE)`, and the engine enforces that ratio. When the enable input is low, the block drives chip select high and then releases SCK, MOSI and chip select to high impedance, so another master can use the same wires. A five-bit status word reports the state of both stores and a busy indication. A one-cycle done pulse marks the end of every accepted exchange.

Top module: `spi_xact_master`

## Requirements
- R1: An accepted exchange with counts T and R gives exactly 8*(T+R) SCK rising edges. `csn_o` goes low before the first edge and stays low without a break until the last byte is finished.
- R2: In the first T byte slots, MOSI carries the command bytes in the order they were pushed, most significant bit first. The bytes received in those slots never appear on `rx_data`.
- R3: In the last R byte slots, MOSI carries 0x00. Each byte sampled from MISO is pushed to the receive store in slot order.
- R4: Mode 0 timing applies. SCK is low whenever `csn_o` is high. MOSI does not change in the cycle where SCK rises. MISO is sampled on the rising edge.
- R5: Each SCK high phase lasts PRESCALE*(1+RATE)/2 clock cycles. With the defaults (PRESCALE=2, RATE=0) that is 1 cycle, so SCK runs at half the input clock.
- R6: While `en` is low, `csn_o` is 1, SCK is low and `start` is ignored. The output enables drop one cycle after `en` falls, so chip select is already high when the lines are released. An exchange in progress is abandoned, and the transmit store is emptied.
- R7: The `status` bits are: bit 0 transmit store empty, bit 1 transmit store not full, bit 2 receive store not empty, bit 3 receive store full, bit 4 busy.
- R8: An accepted start clears the receive store. Status bit 2 reads 0 in the cycle after acceptance.
- R9: A start that arrives while `busy` is high is ignored. The running exchange keeps its original counts, and no second exchange follows it.
- R10: `done` is high for exactly one cycle. That cycle is the first one in which `csn_o` is high again after an exchange.
- R11: A start with both counts zero raises `done` in the next cycle. `csn_o` never goes low, and SCK produces no edges.
- R12: If a command byte is needed but the transmit store is empty, the engine waits with SCK low and `csn_o` still low. It continues once the byte is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low releases the bus |
| start | input | 1 | Begin an exchange (accepted when idle and enabled) |
| tx_count | input | CNT_W | Number of command bytes |
| rx_count | input | CNT_W | Number of response bytes |
| tx_push | input | 1 | Write `tx_data` into the transmit store |
| tx_data | input | 8 | Command byte |
| rx_pop | input | 1 | Remove the head of the receive store |
| rx_data | output | 8 | Head of the receive store |
| status | output | 5 | Store flags and busy, encoded as in R7 |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| sck_o | output | 1 | Serial clock value |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out value |
| mosi_oe | output | 1 | Serial data out enable |
| csn_o | output | 1 | Active-low chip select value |
| csn_oe | output | 1 | Chip select output enable |
| miso_i | input | 1 | Serial data in |

## Verification
The bound checker tests the cycle-level bus rules on every clock. It checks that chip select is low only while busy, that SCK is only high while chip select is low, and that MOSI is stable on each rising SCK edge. It also checks the disabled state, the release order of chip select before its output enable, the single-cycle done pulse, the receive store flush and that a busy start is rejected. The directed scenarios cover what only a byte-accurate slave model can show. These are the edge count per frame, the order of command bytes, the zero fillers, the discarded command-phase bytes, response alignment after an unread earlier response, SCK pulse width, the stall on a missing command byte, and the zero-length exchange.

// File: rtl/spi_xm_pkg.sv
package spi_xm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL,
        ST_DONE
    } xm_state_e;

    // Packed so that bit 0 is the first field listed last.
    typedef struct packed {
        logic busy;       // bit 4
        logic rx_full;    // bit 3
        logic rx_nempty;  // bit 2
        logic tx_nfull;   // bit 1
        logic tx_empty;   // bit 0
    } xm_status_t;

    localparam logic [7:0] FILL_BYTE = 8'h00;

    function automatic bit prescale_ok(int p);
        return (p >= 2) && ((p % 2) == 0);
    endfunction

endpackage

// File: rtl/spi_xm_fifo.sv
module spi_xm_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   fill;
    logic          do_push, do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == (AW+1)'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/spi_xm_halfdiv.sv
module spi_xm_halfdiv #(
    parameter int HALF = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (HALF <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF);
            logic [CW-1:0] cnt;
            assign tick = run && (cnt == CW'(HALF-1));
            always_ff @(posedge clk) begin
                if (rst || !run || tick) cnt <= '0;
                else                     cnt <= cnt + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/spi_xm_shifter.sv
module spi_xm_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       sample,
    input  logic       shift,
    input  logic       miso,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       last_bit
);
    logic [7:0] tx_sr;
    logic [7:0] rx_sr;
    logic [2:0] bit_idx;

    assign mosi     = tx_sr[7];
    assign rx_byte  = rx_sr;
    assign last_bit = (bit_idx == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            bit_idx <= '0;
        end else begin
            if (load) begin
                tx_sr   <= din;
                bit_idx <= '0;
            end else if (shift) begin
                tx_sr   <= {tx_sr[6:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
            end
            if (sample) rx_sr <= {rx_sr[6:0], miso};
        end
    end

endmodule

// File: rtl/spi_xact_master.sv
module spi_xact_master
    import spi_xm_pkg::*;
#(
    parameter int PRESCALE = 2,
    parameter int RATE     = 0,
    parameter int CNT_W    = 8,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             tx_push,
    input  logic [7:0]       tx_data,
    input  logic             rx_pop,
    output logic [7:0]       rx_data,
    output logic [4:0]       status,
    output logic             busy,
    output logic             done,
    output logic             sck_o,
    output logic             sck_oe,
    output logic             mosi_o,
    output logic             mosi_oe,
    output logic             csn_o,
    output logic             csn_oe,
    input  logic             miso_i
);
    localparam int HALF = (PRESCALE * (1 + RATE)) / 2;

    generate
        if (!prescale_ok(PRESCALE)) begin : g_bad_prescale
            $error("spi_xact_master: PRESCALE must be even and >= 2");
        end
    endgenerate

    xm_state_e        state;
    logic [CNT_W-1:0] tx_left, rx_left;
    logic             cmd_phase;
    logic             bus_on;

    logic             tick, run, active;
    logic             start_ok, need_cmd, load_go, last_slot;
    logic             sample, shift, byte_end, rx_push;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic [7:0]       tx_head, rx_byte, load_byte;
    logic             sh_mosi, last_bit;
    xm_status_t       st;

    assign active    = (state == ST_LEAD) || (state == ST_LOAD) || (state == ST_LOW)
                    || (state == ST_HIGH) || (state == ST_TRAIL);
    assign run       = (state == ST_LEAD) || (state == ST_LOW)
                    || (state == ST_HIGH) || (state == ST_TRAIL);
    assign start_ok  = start && en && bus_on && (state == ST_IDLE);
    assign need_cmd  = (tx_left != '0);
    assign load_go   = (state == ST_LOAD) && (need_cmd ? !tx_empty : !rx_full);
    assign load_byte = need_cmd ? tx_head : FILL_BYTE;
    assign sample    = (state == ST_LOW) && tick;
    assign shift     = (state == ST_HIGH) && tick && !last_bit;
    assign byte_end  = (state == ST_HIGH) && tick && last_bit;
    assign rx_push   = byte_end && !cmd_phase;
    assign last_slot = cmd_phase ? ((tx_left == CNT_W'(1)) && (rx_left == '0))
                                 : (rx_left == CNT_W'(1));

    spi_xm_halfdiv #(.HALF(HALF)) u_div (
        .clk (clk), .rst (rst), .run (run), .tick (tick)
    );

    spi_xm_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load_go),
        .din      (load_byte),
        .sample   (sample),
        .shift    (shift),
        .miso     (miso_i),
        .mosi     (sh_mosi),
        .rx_byte  (rx_byte),
        .last_bit (last_bit)
    );

    spi_xm_fifo #(.DEPTH(TX_DEPTH), .W(8)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .flush (!en),
        .push  (tx_push),
        .din   (tx_data),
        .pop   (load_go && need_cmd),
        .dout  (tx_head),
        .empty (tx_empty),
        .full  (tx_full)
    );

    spi_xm_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .flush (start_ok),
        .push  (rx_push),
        .din   (rx_byte),
        .pop   (rx_pop),
        .dout  (rx_data),
        .empty (rx_empty),
        .full  (rx_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tx_left   <= '0;
            rx_left   <= '0;
            cmd_phase <= 1'b0;
            bus_on    <= 1'b0;
        end else begin
            bus_on <= en;
            if (!en) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (start_ok) begin
                        tx_left <= tx_count;
                        rx_left <= rx_count;
                        state   <= ((tx_count == '0) && (rx_count == '0)) ? ST_DONE : ST_LEAD;
                    end
                    ST_LEAD: if (tick) state <= ST_LOAD;
                    ST_LOAD: if (load_go) begin
                        cmd_phase <= need_cmd;
                        state     <= ST_LOW;
                    end
                    ST_LOW:  if (tick) state <= ST_HIGH;
                    ST_HIGH: if (tick) begin
                        if (last_bit) begin
                            if (cmd_phase) tx_left <= tx_left - 1'b1;
                            else           rx_left <= rx_left - 1'b1;
                            state <= last_slot ? ST_TRAIL : ST_LOAD;
                        end else begin
                            state <= ST_LOW;
                        end
                    end
                    ST_TRAIL: if (tick) state <= ST_DONE;
                    ST_DONE:  state <= ST_IDLE;
                    default:  state <= ST_IDLE;
                endcase
            end
        end
    end

    assign busy   = (state != ST_IDLE);
    assign done   = (state == ST_DONE);
    assign sck_o  = en && (state == ST_HIGH);
    assign csn_o  = !(en && active);
    assign mosi_o = active ? sh_mosi : 1'b0;
    assign sck_oe  = bus_on;
    assign mosi_oe = bus_on;
    assign csn_oe  = bus_on;

    always_comb begin
        st.busy      = busy;
        st.rx_full   = rx_full;
        st.rx_nempty = !rx_empty;
        st.tx_nfull  = !tx_full;
        st.tx_empty  = tx_empty;
    end
    assign status = st;

endmodule

// File: rtl/spi_xm_chk.sv
module spi_xm_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [4:0] status,
    input logic       sck_o,
    input logic       mosi_o,
    input logic       csn_o,
    input logic       csn_oe
);
    // R1
    cs_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !csn_o |-> busy);

    // R4
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        sck_o |-> !csn_o);

    // R4
    mosi_steady_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sck_o) |-> $stable(mosi_o));

    // R6
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (csn_o && !sck_o));

    // R6
    cs_release_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(csn_oe) |-> $past(csn_o));

    // R8
    rx_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (start && en && csn_oe && !busy) |=> !status[2]);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && en && busy && !done) |=> busy);

    // R10
    done_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> csn_o);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind spi_xact_master spi_xm_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .status (status),
    .sck_o  (sck_o),
    .mosi_o (mosi_o),
    .csn_o  (csn_o),
    .csn_oe (csn_oe)
);

// File: tb/spi_xact_master_tb_top.sv
`timescale 1ns/1ps
module spi_xact_master_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tx_count = '0;
    logic [7:0] rx_count = '0;
    logic       tx_push = 1'b0;
    logic [7:0] tx_data = '0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_data;
    logic [4:0] status;
    logic       busy, done;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, csn_o, csn_oe;
    logic       miso = 1'b0;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    spi_xact_master dut_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .start    (start),
        .tx_count (tx_count),
        .rx_count (rx_count),
        .tx_push  (tx_push),
        .tx_data  (tx_data),
        .rx_pop   (rx_pop),
        .rx_data  (rx_data),
        .status   (status),
        .busy     (busy),
        .done     (done),
        .sck_o    (sck_o),
        .sck_oe   (sck_oe),
        .mosi_o   (mosi_o),
        .mosi_oe  (mosi_oe),
        .csn_o    (csn_o),
        .csn_oe   (csn_oe),
        .miso_i   (miso)
    );

    // ---------------- slave model ----------------
    logic [7:0] seed = 8'h00;
    logic [7:0] cap [64];
    int         ncap = 0;
    int         rises = 0;

    function automatic logic [7:0] resp(logic [7:0] sd, int k);
        return (sd ^ 8'h5A) + 8'(k * 29);
    endfunction

    initial begin : slave
        logic [7:0] sr;
        logic [7:0] nb;
        int bi, bk;
        bit inframe;
        forever begin
            @(negedge csn_o);
            bi = 0; bk = 0; sr = '0;
            nb = resp(seed, 0);
            miso = nb[7];
            inframe = 1'b1;
            while (inframe) begin
                @(posedge sck_o or posedge csn_o);
                if (csn_o) inframe = 1'b0;
                else begin
                    sr = {sr[6:0], mosi_o};
                    rises++;
                    bi++;
                    if (bi == 8) begin
                        if (ncap < 64) cap[ncap] = sr;
                        ncap++;
                        bi = 0;
                        bk++;
                    end
                    @(negedge sck_o or posedge csn_o);
                    if (csn_o) inframe = 1'b0;
                    else begin
                        nb = resp(seed, bk);
                        miso = nb[7-bi];
                    end
                end
            end
        end
    end

    // ---------------- SCK high width monitor (R5) ----------------
    int hi_run = 0, w_seen = 0, w_bad = 0;
    initial begin : width_mon
        forever begin
            @(negedge clk);
            if (sck_o === 1'b1) hi_run++;
            else if (hi_run > 0) begin
                w_seen++;
                if (hi_run != 1) w_bad++;
                hi_run = 0;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        tx_push = 1'b1; tx_data = b;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic kick(input int t, input int r);
        @(negedge clk);
        start = 1'b1; tx_count = 8'(t); rx_count = 8'(r);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (done !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " R10 done seen"}, done, 1'b1);
        chk({req, " R10 cs high at done"}, csn_o, 1'b1);
        @(negedge clk);
        chk({req, " R10 done one cycle"}, done, 1'b0);
    endtask

    function automatic logic [7:0] cmd_of(logic [7:0] sd, int i);
        return sd + 8'(i * 7) + 8'd1;
    endfunction

    task automatic run_frame(input int t, input int r, input logic [7:0] sd, input bit do_pop);
        for (int i = 0; i < t; i++) push_byte(cmd_of(sd, i));
        seed = sd; ncap = 0; rises = 0;
        kick(t, r);
        chk("R8 rx flushed after start", status[2], 1'b0);
        chk("R7 busy bit during frame", status[4], 1'b1);
        wait_done("frame");
        chk("R1 sck rising edges", rises, 8 * (t + r));
        chk("R1 bytes in one cs window", ncap, t + r);
        for (int i = 0; i < t; i++) chk("R2 command byte on mosi", cap[i], cmd_of(sd, i));
        for (int i = 0; i < r; i++) chk("R3 filler byte 0x00", cap[t + i], 8'h00);
        if (do_pop) begin
            for (int i = 0; i < r; i++) begin
                chk("R3 R2 response byte (command slots dropped)", rx_data, resp(sd, t + i));
                rx_pop = 1'b1;
                @(negedge clk);
                rx_pop = 1'b0;
            end
            chk("R2 no extra received bytes", status[2], 1'b0);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        chk("R6 reset cs high", csn_o, 1'b1);
        chk("R6 reset oe off", {sck_oe, mosi_oe, csn_oe}, 3'b000);
        chk("R7 reset status", status, 5'b00011);
        chk("R10 reset done low", done, 1'b0);
    endtask

    task automatic t_basic;
        run_frame(4, 2, 8'h11, 1'b1);
        run_frame(1, 3, 8'h92, 1'b1);
        run_frame(2, 0, 8'h3C, 1'b1);
        run_frame(0, 2, 8'hE7, 1'b1);
    endtask

    task automatic t_status_full;
        for (int i = 0; i < 8; i++) push_byte(cmd_of(8'h40, i));
        chk("R7 tx full status", status, 5'b00000);
        seed = 8'h40; ncap = 0; rises = 0;
        kick(8, 0);
        wait_done("full");
        chk("R2 eight commands sent", ncap, 8);
        chk("R2 last command byte", cap[7], cmd_of(8'h40, 7));
        run_frame(1, 8, 8'h77, 1'b0);
        chk("R7 rx full status", status, 5'b01111);
        // stale responses left unread; next frame must line up (R8)
        run_frame(2, 2, 8'hA5, 1'b1);
    endtask

    task automatic t_zero;
        ncap = 0; rises = 0;
        kick(0, 0);
        chk("R11 done next cycle", done, 1'b1);
        chk("R11 cs never low", csn_o, 1'b1);
        @(negedge clk);
        chk("R11 done cleared", done, 1'b0);
        chk("R11 no sck edges", rises, 0);
    endtask

    task automatic t_busy_start;
        push_byte(cmd_of(8'h21, 0));
        push_byte(cmd_of(8'h21, 1));
        seed = 8'h21; ncap = 0; rises = 0;
        kick(2, 1);
        repeat (6) @(negedge clk);
        start = 1'b1; tx_count = 8'd5; rx_count = 8'd5;
        @(negedge clk);
        start = 1'b0;
        wait_done("busy");
        chk("R9 frame length kept", rises, 24);
        repeat (3) @(negedge clk);
        chk("R9 no follow-up frame", busy, 1'b0);
        chk("R9 response byte", rx_data, resp(8'h21, 2));
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic t_stall;
        push_byte(cmd_of(8'h66, 0));
        seed = 8'h66; ncap = 0; rises = 0;
        kick(2, 1);
        repeat (40) @(negedge clk);
        chk("R12 cs held low while waiting", csn_o, 1'b0);
        chk("R12 sck low while waiting", sck_o, 1'b0);
        chk("R12 only first byte clocked", rises, 8);
        push_byte(cmd_of(8'h66, 1));
        wait_done("stall");
        chk("R12 second command after stall", cap[1], cmd_of(8'h66, 1));
        chk("R12 response after stall", rx_data, resp(8'h66, 2));
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic t_disable;
        for (int i = 0; i < 3; i++) push_byte(cmd_of(8'h0F, i));
        seed = 8'h0F; ncap = 0; rises = 0;
        kick(3, 3);
        repeat (10) @(negedge clk);
        chk("R6 frame running before disable", csn_o, 1'b0);
        en = 1'b0;
        #0.5;
        chk("R6 cs high before release", csn_o, 1'b1);
        chk("R6 cs still driven", csn_oe, 1'b1);
        @(negedge clk);
        chk("R6 lines released", {sck_oe, mosi_oe, csn_oe}, 3'b000);
        chk("R6 abandoned", busy, 1'b0);
        kick(1, 1);
        chk("R6 start ignored when off", busy, 1'b0);
        chk("R6 tx store emptied", status[0], 1'b1);
        en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_width;
        chk("R5 sck pulses observed", (w_seen > 0), 1'b1);
        chk("R5 sck high width", w_bad, 0);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin : watchdog
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        en = 1'b1;
        repeat (2) @(negedge clk);
        t_basic();
        t_zero();
        t_status_full();
        t_busy_start();
        t_stall();
        t_disable();
        run_frame(3, 2, 8'h5D, 1'b1);
        t_width();
        summary();
        $finish;
    end

endmodule